// File: doc/BRIEF.md
# Multiplexer look-up-table state machine

This block is a two-bit synchronous state machine with one data input `x`. Its next-state logic is built from two 4-to-1 multiplexers, not from gate equations. The data inputs of each multiplexer are four programmable bits, so each multiplexer works as a small look-up table. The select lines of each multiplexer are wired to fixed state and input signals. The outputs are the two current state bits `y1` and `y0`.

The eight table bits are written through a configuration port in a single cycle. The machine holds its state in any cycle where configuration is requested. A synchronous reset returns the state to `ST_00` and loads a default programming. With that default, the high next-state bit is the XNOR of the two state bits, and the low next-state bit is the XOR of `y1` and `x`.

Internally the state `{y1,y0}` is an enumeration with the values `ST_00`, `ST_01`, `ST_10` and `ST_11`. In every cycle a control decoder picks one of three actions. `ACT_RESET` forces `ST_00` and the default tables. `ACT_LOAD` writes the tables and holds the state. `ACT_STEP` moves the state to whatever the two multiplexers select, so any of the four states can be reached from any other, depending on the table contents and `x`.

Top module: `mux_lut_fsm`

## Requirements
- R1: The high next-state bit comes from table H, made of `cfg_word[3:0]` with bit k holding entry Ik. Table H is selected with S1 = `y0` and S0 = `y1`, so the entry used is I(2*y0 + y1).
- R2: The low next-state bit comes from table L, made of `cfg_word[7:4]` with bit 4+k holding entry Ik. Table L is selected with S1 = `y1` and S0 = `x`, so the entry used is I(2*y1 + x).
- R3: In a cycle with `rst` and `cfg_en` both low, the selected high and low bits are captured into `y1` and `y0` on the rising clock edge.
- R4: A synchronous active-high `rst` clears `{y1,y0}` to 00. It also loads the default tables: table H entries I0..I3 = 1,0,0,1 and table L entries I0..I3 = 0,1,1,0, which is `cfg_word` value 8'h69.
- R5: With `cfg_en` high and `rst` low, all eight table bits take the value of `cfg_word` at that clock edge.
- R6: `{y1,y0}` does not change in any cycle where `cfg_en` is high.
- R7: With the default tables, the next `y1` is XNOR(`y0`,`y1`) and the next `y0` is XOR(`y1`,`x`). In particular, state 11 goes to 11 when `x`=0 and to 10 when `x`=1.
- R8: `rst` takes priority over `cfg_en`. When both are high, the state becomes 00, the default tables are loaded, and `cfg_word` has no effect.
- R9: Tables loaded in one cycle govern the state step in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Load both tables from `cfg_word`, hold the state |
| cfg_word | input | 8 | Table contents: [3:0] table H, [7:4] table L |
| x | input | 1 | Machine input, select S0 of table L |
| y1 | output | 1 | High state bit |
| y0 | output | 1 | Low state bit |

## Verification
The assertions are checked on every clock edge. They cover the select routing of both tables in states where a single entry is determined (R1, R2), the load of the configuration word (R5), the held state during configuration (R6), and the result of reset, including its priority over configuration (R4, R8). The bench scenarios cover the rest. They drive all eight (`y1`,`y0`,`x`) combinations under the default and a non-default programming (R3, R7). They show that a new programming governs the very next step (R9), and that a configuration word presented together with reset is dropped, which only a later step can reveal.

// File: rtl/mlf_pkg.sv
package mlf_pkg;

    // number of select lines per look-up multiplexer
    localparam int SEL_W     = 2;
    // entries per look-up table
    localparam int LUT_DEPTH = 1 << SEL_W;
    // number of next-state bits, one table each
    localparam int NUM_NEXT  = 2;
    // total configuration bits
    localparam int CFG_W     = NUM_NEXT * LUT_DEPTH;

    // table H (high bit) = 1,0,0,1 ; table L (low bit) = 0,1,1,0
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'h69;

    // state encoding is {y1, y0}
    typedef enum logic [1:0] {
        ST_00 = 2'b00,
        ST_01 = 2'b01,
        ST_10 = 2'b10,
        ST_11 = 2'b11
    } state_e;

    typedef enum logic [1:0] {
        ACT_STEP  = 2'b00,
        ACT_LOAD  = 2'b01,
        ACT_RESET = 2'b10
    } act_e;

endpackage

// File: rtl/mlf_ctrl.sv
module mlf_ctrl
    import mlf_pkg::*;
(
    input  logic rst,
    input  logic cfg_en,
    output act_e act
);

    // reset wins over configuration, configuration wins over stepping
    always_comb begin
        unique casez ({rst, cfg_en})
            2'b1?:   act = ACT_RESET;
            2'b01:   act = ACT_LOAD;
            default: act = ACT_STEP;
        endcase
    end

endmodule

// File: rtl/mlf_lut_bank.sv
module mlf_lut_bank
    import mlf_pkg::*;
#(
    parameter int               BANK_W  = CFG_W,
    parameter logic [BANK_W-1:0] INIT_V = CFG_DEFAULT
) (
    input  logic              clk,
    input  act_e              act,
    input  logic [BANK_W-1:0] cfg_word,
    output logic [BANK_W-1:0] lut_bits
);

    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: lut_bits <= INIT_V;
            ACT_LOAD:  lut_bits <= cfg_word;
            default:   lut_bits <= lut_bits;
        endcase
    end

endmodule

// File: rtl/mlf_lut_mux.sv
module mlf_lut_mux
    import mlf_pkg::*;
#(
    parameter int SW    = SEL_W,
    localparam int DEPTH = 1 << SW
) (
    input  logic [DEPTH-1:0] data,
    input  logic [SW-1:0]    sel,   // sel[SW-1] is S1 ... sel[0] is S0
    output logic             out
);

    always_comb begin
        out = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            if (sel == SW'(k)) out = data[k];
        end
    end

endmodule

// File: rtl/mlf_state_reg.sv
module mlf_state_reg
    import mlf_pkg::*;
(
    input  logic clk,
    input  act_e act,
    input  logic nxt_hi,
    input  logic nxt_lo,
    output logic y1,
    output logic y0
);

    state_e state;

    // state register
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: state <= ST_00;
            ACT_LOAD:  state <= state;
            default:   state <= state_e'({nxt_hi, nxt_lo});
        endcase
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_00:   {y1, y0} = 2'b00;
            ST_01:   {y1, y0} = 2'b01;
            ST_10:   {y1, y0} = 2'b10;
            ST_11:   {y1, y0} = 2'b11;
            default: {y1, y0} = 2'b00;
        endcase
    end

    logic seen_edge;
    logic was_reset;
    always_ff @(posedge clk) begin
        seen_edge <= 1'b1;
        was_reset <= (act == ACT_RESET);
    end

    // R4: one edge after a reset action the state reads 00
    always_ff @(posedge clk) begin
        if (seen_edge === 1'b1 && was_reset === 1'b1) begin
            a_r4_reset_state: assert (state == ST_00)
                else $error("R4: state not 00 after reset");
        end
    end

    // R6: a load action leaves the state untouched
    a_r6_hold_on_load: assert property (@(posedge clk) disable iff (act == ACT_RESET)
        (act == ACT_LOAD) |=> $stable(state));

endmodule

// File: rtl/mux_lut_fsm.sv
module mux_lut_fsm
    import mlf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             x,
    output logic             y1,
    output logic             y0
);

    localparam int HI_BASE = 0;
    localparam int LO_BASE = LUT_DEPTH;

    act_e               act;
    logic [CFG_W-1:0]   lut_bits;
    logic [NUM_NEXT-1:0] mux_out;   // [0] = high next bit, [1] = low next bit

    mlf_ctrl u_ctrl (
        .rst    (rst),
        .cfg_en (cfg_en),
        .act    (act)
    );

    mlf_lut_bank #(
        .BANK_W (CFG_W),
        .INIT_V (CFG_DEFAULT)
    ) u_bank (
        .clk      (clk),
        .act      (act),
        .cfg_word (cfg_word),
        .lut_bits (lut_bits)
    );

    // fixed select routing per table
    for (genvar g = 0; g < NUM_NEXT; g++) begin : g_lut
        logic [SEL_W-1:0] sel;
        if (g == 0) begin : g_hi
            assign sel = {y0, y1};   // S1 = y0, S0 = y1
        end else begin : g_lo
            assign sel = {y1, x};    // S1 = y1, S0 = x
        end
        mlf_lut_mux #(
            .SW (SEL_W)
        ) u_mux (
            .data (lut_bits[g*LUT_DEPTH +: LUT_DEPTH]),
            .sel  (sel),
            .out  (mux_out[g])
        );
    end

    mlf_state_reg u_state (
        .clk    (clk),
        .act    (act),
        .nxt_hi (mux_out[0]),
        .nxt_lo (mux_out[1]),
        .y1     (y1),
        .y0     (y0)
    );

    // R5: the tables take the word presented with cfg_en
    a_r5_cfg_load: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (lut_bits == $past(cfg_word)));

    // R1: from state 11 a step puts table H entry I3 into y1
    a_r1_hi_route: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && y1 && y0) |=> (y1 == $past(lut_bits[HI_BASE + 3])));

    // R2: from a state with y1 = 0 a step puts table L entry I0 or I1 into y0
    a_r2_lo_route: assert property (@(posedge clk) disable iff (rst)
        (!cfg_en && !y1) |=> (y0 == $past(x ? lut_bits[LO_BASE + 1] : lut_bits[LO_BASE])));

    // R8: after reset, even with cfg_en high, the default tables are present
    logic rst_q;
    logic edge_q;
    always_ff @(posedge clk) begin
        rst_q  <= rst;
        edge_q <= 1'b1;
    end
    always_ff @(posedge clk) begin
        if (edge_q === 1'b1 && rst_q === 1'b1) begin
            a_r8_reset_default: assert (lut_bits == CFG_DEFAULT)
                else $error("R8: tables not default after reset");
        end
    end

endmodule

// File: tb/sim_mux_lut_fsm.sv
`timescale 1ns/1ps
module sim_mux_lut_fsm;

    logic       clk;
    logic       rst;
    logic       cfg_en;
    logic [7:0] cfg_word;
    logic       x;
    logic       y1;
    logic       y0;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    mux_lut_fsm u0 (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_word (cfg_word),
        .x        (x),
        .y1       (y1),
        .y0       (y0)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // each entry: {cfg_word[7:0], start y1, start y0, x, expected y1, expected y0}
    localparam int NV = 16;
    localparam logic [12:0] VEC [NV] = '{
        // default programming 8'h69 (R7)
        {8'h69, 2'b00, 1'b0, 2'b10},
        {8'h69, 2'b00, 1'b1, 2'b11},
        {8'h69, 2'b01, 1'b0, 2'b00},
        {8'h69, 2'b01, 1'b1, 2'b01},
        {8'h69, 2'b10, 1'b0, 2'b01},
        {8'h69, 2'b10, 1'b1, 2'b00},
        {8'h69, 2'b11, 1'b0, 2'b11},
        {8'h69, 2'b11, 1'b1, 2'b10},
        // non-default 8'hC3: high = not y0, low = y1
        {8'hC3, 2'b00, 1'b0, 2'b10},
        {8'hC3, 2'b00, 1'b1, 2'b10},
        {8'hC3, 2'b01, 1'b0, 2'b00},
        {8'hC3, 2'b01, 1'b1, 2'b00},
        {8'hC3, 2'b10, 1'b0, 2'b11},
        {8'hC3, 2'b10, 1'b1, 2'b11},
        {8'hC3, 2'b11, 1'b0, 2'b01},
        {8'hC3, 2'b11, 1'b1, 2'b01}
    };

    task automatic cyc(input logic r, input logic c, input logic [7:0] w, input logic xi);
        rst = r; cfg_en = c; cfg_word = w; x = xi;
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // table word whose entries are constant, forcing the next state to t
    function automatic logic [7:0] force_word(input logic [1:0] t);
        return {{4{t[0]}}, {4{t[1]}}};
    endfunction

    initial begin
        rst = 1'b1; cfg_en = 1'b0; cfg_word = 8'h00; x = 1'b0;
        cyc(1'b1, 1'b0, 8'h00, 1'b0);
        cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R4 reset state", {y1, y0}, 2'b00);

        // default tables straight after reset: 00,x=0 -> 10 (R4, R7)
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R4 default tables", {y1, y0}, 2'b10);

        // vector walk
        for (int i = 0; i < NV; i++) begin
            logic [7:0] w;
            logic [1:0] st;
            logic       xi;
            logic [1:0] ex;
            w  = VEC[i][12:5];
            st = VEC[i][4:3];
            xi = VEC[i][2];
            ex = VEC[i][1:0];
            cyc(1'b0, 1'b1, force_word(st), 1'b0);   // load forcing tables
            cyc(1'b0, 1'b0, 8'h00, 1'b0);            // step into start state
            chk("R3 reach start", {y1, y0}, st);
            cyc(1'b0, 1'b1, w, ~xi);                 // load test tables, x toggled
            chk("R6 hold on load", {y1, y0}, st);
            cyc(1'b0, 1'b0, 8'h00, xi);              // first step uses new tables
            if (w == 8'h69) chk("R7/R1/R2 default step", {y1, y0}, ex);
            else            chk("R9/R1/R2 new tables step", {y1, y0}, ex);
        end

        // R7 chain under defaults: reset, then 00 -x1-> 11 -x0-> 11 -x1-> 10
        cyc(1'b1, 1'b0, 8'h00, 1'b0);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R7 00 x1", {y1, y0}, 2'b11);
        cyc(1'b0, 1'b0, 8'h00, 1'b0);
        chk("R7 11 x0", {y1, y0}, 2'b11);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R7 11 x1", {y1, y0}, 2'b10);

        // R8: reset together with cfg_en and an all-zero word
        cyc(1'b1, 1'b1, 8'h00, 1'b1);
        chk("R8 state after reset+cfg", {y1, y0}, 2'b00);
        cyc(1'b0, 1'b0, 8'hFF, 1'b0);   // word ignored without cfg_en
        chk("R8 default kept", {y1, y0}, 2'b10);

        // R5: all-ones tables send every state to 11
        cyc(1'b0, 1'b1, 8'hFF, 1'b0);
        chk("R6 hold 10", {y1, y0}, 2'b10);
        cyc(1'b0, 1'b0, 8'h00, 1'b1);
        chk("R5 all ones", {y1, y0}, 2'b11);

        // reset from a nonzero state (R4)
        cyc(1'b1, 1'b0, 8'h00, 1'b0);
        chk("R4 reset from 11", {y1, y0}, 2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule